// File: doc/BRIEF.md
# ADC Sequence Status Tracker

This block holds the status word of a successive-approximation ADC sequencer. Strobes from the sequencer report each finished conversion and each finished sequence. It also sees external trigger edges, bus writes to the control, compare and start registers, and reads of result slots. From these it keeps three sticky flags and a conversion counter. The flags are: sequence done, trigger overrun and result overrun. The counter names the result slot that the conversion now in progress will fill.

The status word is read through an 8-bit port. Software clears each flag by writing 1 to its bit. Flags are also cleared automatically when a new sequence starts, when the sequence is aborted by a control write, and, for the sequence-done flag, on a result read in auto-clear mode. The converter, the sampling and the result storage are outside the block. The per-slot conversion-complete flags arrive as an input vector.

Top module: `adc_seq_status`

## Requirements
- R1: The sequence-done flag (status bit 7) is 1 in the cycle after every `seq_done_i` pulse, including back-to-back sequences in scan operation.
- R2: The sequence-done flag goes to 0 after a status write with bit 7 = 1, after a `wr_start_i` pulse, or after `res_rd_i` while `auto_clr_i` = 1. A result read with `auto_clr_i` = 0 leaves it set.
- R3: The trigger overrun flag (status bit 5) sets when `trig_edge_i`, `seq_busy_i` and `edge_mode_i` are all 1. With `edge_mode_i` = 0, or with no sequence busy, a trigger edge does not set it.
- R4: The trigger overrun flag and the result overrun flag (status bit 4) go to 0 after a status write of 1 to their own bit, after `wr_ctrl_i`, or after `wr_start_i`.
- R5: The result overrun flag sets when `conv_done_i` arrives while `ccf_i[c]` = 1, where c is the current counter value.
- R6: The counter (status bits 3:0) adds 1 on each `conv_done_i` and wraps from 15 to 0.
- R7: With `fifo_mode_i` = 0, the counter is 0 after a `seq_done_i`. With `fifo_mode_i` = 1, `seq_done_i` does not reset it, and a conversion in the same cycle still increments it.
- R8: `wr_start_i` or `wr_ctrl_i` loads the counter with 0 in both modes. This takes priority over any increment.
- R9: Status bit 6 reads 0, and a status write never changes bits 3:0.
- R10: If a flag's set event and any of its clear events fall in the same cycle, the flag is 1 afterwards.
- R11: With `rst_n` low at a clock edge, every flag and the counter become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done_i | input | 1 | One conversion finished; its result goes to the current slot |
| seq_done_i | input | 1 | A conversion sequence finished |
| seq_busy_i | input | 1 | A sequence is in progress |
| trig_edge_i | input | 1 | Active external trigger edge detected |
| edge_mode_i | input | 1 | 1 = edge-triggered operation |
| fifo_mode_i | input | 1 | 1 = counter runs on across sequences |
| auto_clr_i | input | 1 | 1 = a result read clears the sequence-done flag |
| wr_ctrl_i | input | 1 | Write to a control or compare register (abort) |
| wr_start_i | input | 1 | Write to the sequence-start register |
| stat_wr_i | input | 1 | Write strobe for the status register |
| stat_wdata_i | input | 8 | Status write data; 1 bits clear flags |
| res_rd_i | input | 1 | A result slot was read |
| ccf_i | input | 16 | Per-slot conversion-complete flags |
| stat_rdata_o | output | 8 | Status word {seq_done, 0, trig_ovr, res_ovr, counter} |

## Verification
A vector table runs through sequences in both counter modes. Lone strobes show each set and clear path separately. Paired strobes in one cycle separate "set wins" from "clear wins" and show that abort outranks increment. Trigger edges are applied in level mode, in edge mode with no sequence busy, and in edge mode during a sequence, so that only the last case sets the overrun flag. Directed runs count sixteen conversions to catch a wrap that is missing or off by one, and apply reset while flags are set.

// File: rtl/adc_stat_pkg.sv
// Package: shared status-word layout and counter action encoding.
// Assumes: 8-bit status word; bit positions are decoded by software.
package adc_stat_pkg;
    localparam int STAT_W      = 8;
    localparam int SEQ_BIT     = 7;
    localparam int TRIG_BIT    = 5;
    localparam int RES_BIT     = 4;
    localparam int NUM_FLAGS   = 3;
    localparam int FLAG_SEQ    = 0;
    localparam int FLAG_TRIG   = 1;
    localparam int FLAG_RES    = 2;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_ZERO = 2'd1,
        CNT_INC  = 2'd2
    } cnt_op_e;
endpackage

// File: rtl/adc_status_flag.sv
// Module: one sticky status flag with a set input and a clear input.
// Assumes: set and clear are single-cycle strobes; set outranks clear.
module adc_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold the flag; set wins, else clear, else keep.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_o <= 1'b0;
        else if (set_i)   flag_o <= 1'b1;
        else if (clr_i)   flag_o <= 1'b0;
    end
endmodule

// File: rtl/adc_slot_counter.sv
// Module: counter that points at the result slot the current conversion fills.
// Assumes: restart (abort/start) outranks everything; in non-FIFO mode the
// end of a sequence zeroes it, in FIFO mode it runs on and wraps.
module adc_slot_counter
    import adc_stat_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             conv_i,
    input  logic             seq_end_i,
    input  logic             fifo_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cnt_op_e op;

    // Pick the counter action for this cycle.
    always_comb begin
        if (restart_i)                 op = CNT_ZERO;
        else if (seq_end_i && !fifo_i) op = CNT_ZERO;
        else if (conv_i)               op = CNT_INC;
        else                           op = CNT_HOLD;
    end

    // Apply the chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else begin
            case (op)
                CNT_ZERO: cnt_o <= '0;
                CNT_INC:  cnt_o <= cnt_o + 1'b1;
                default:  cnt_o <= cnt_o;
            endcase
        end
    end

    assert_cnt_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_o == '0));

    assert_cnt_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_i && !restart_i && !seq_end_i && cnt_o == CNT_MAX) |=> (cnt_o == '0));

    assert_cnt_end_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_end_i && !fifo_i) |=> (cnt_o == '0));

    assert_cnt_fifo_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_end_i && fifo_i && !conv_i && !restart_i) |=> $stable(cnt_o));
endmodule

// File: rtl/adc_seq_status.sv
// Module: status tracker for an ADC conversion sequencer.
// Assumes: all inputs are synchronous single-cycle strobes or levels;
// ccf_i is owned by result storage outside; set events outrank clears.
module adc_seq_status
    import adc_stat_pkg::*;
#(
    parameter int CNT_W = 4,
    localparam int NUM_SLOTS = 1 << CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 conv_done_i,
    input  logic                 seq_done_i,
    input  logic                 seq_busy_i,
    input  logic                 trig_edge_i,
    input  logic                 edge_mode_i,
    input  logic                 fifo_mode_i,
    input  logic                 auto_clr_i,
    input  logic                 wr_ctrl_i,
    input  logic                 wr_start_i,
    input  logic                 stat_wr_i,
    input  logic [STAT_W-1:0]    stat_wdata_i,
    input  logic                 res_rd_i,
    input  logic [NUM_SLOTS-1:0] ccf_i,
    output logic [STAT_W-1:0]    stat_rdata_o
);
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [CNT_W-1:0]     slot_cnt;
    logic                 restart;

    assign restart = wr_ctrl_i | wr_start_i;

    // Decode set and clear events for each flag.
    always_comb begin
        flag_set[FLAG_SEQ]  = seq_done_i;
        flag_set[FLAG_TRIG] = edge_mode_i & trig_edge_i & seq_busy_i;
        flag_set[FLAG_RES]  = conv_done_i & ccf_i[slot_cnt];
        flag_clr[FLAG_SEQ]  = (stat_wr_i & stat_wdata_i[SEQ_BIT]) | wr_start_i
                            | (res_rd_i & auto_clr_i);
        flag_clr[FLAG_TRIG] = (stat_wr_i & stat_wdata_i[TRIG_BIT]) | restart;
        flag_clr[FLAG_RES]  = (stat_wr_i & stat_wdata_i[RES_BIT]) | restart;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        adc_status_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[g]),
            .clr_i  (flag_clr[g]),
            .flag_o (flag_q[g])
        );
    end

    adc_slot_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .conv_i    (conv_done_i),
        .seq_end_i (seq_done_i),
        .fifo_i    (fifo_mode_i),
        .cnt_o     (slot_cnt)
    );

    // Assemble the status word; unused bits read 0.
    always_comb begin
        stat_rdata_o           = '0;
        stat_rdata_o[SEQ_BIT]  = flag_q[FLAG_SEQ];
        stat_rdata_o[TRIG_BIT] = flag_q[FLAG_TRIG];
        stat_rdata_o[RES_BIT]  = flag_q[FLAG_RES];
        stat_rdata_o[CNT_W-1:0] = slot_cnt;
    end

    assert_seq_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_i |=> stat_rdata_o[SEQ_BIT]);

    assert_seq_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_done_i && (wr_start_i || (res_rd_i && auto_clr_i)
                         || (stat_wr_i && stat_wdata_i[SEQ_BIT])))
        |=> !stat_rdata_o[SEQ_BIT]);

    assert_trig_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && trig_edge_i && seq_busy_i) |=> stat_rdata_o[TRIG_BIT]);

    assert_trig_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode_i && !stat_rdata_o[TRIG_BIT]) |=> !stat_rdata_o[TRIG_BIT]);

    assert_ovr_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !(edge_mode_i && trig_edge_i && seq_busy_i) && !conv_done_i)
        |=> (!stat_rdata_o[TRIG_BIT] && !stat_rdata_o[RES_BIT]));

    assert_res_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done_i && ccf_i[stat_rdata_o[CNT_W-1:0]]) |=> stat_rdata_o[RES_BIT]);

    assert_cnt_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && !conv_done_i && !seq_done_i && !restart)
        |=> $stable(stat_rdata_o[CNT_W-1:0]));
endmodule

// File: tb/tb_adc_seq_status.sv
module tb_adc_seq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done_i = 0, seq_done_i = 0, seq_busy_i = 0, trig_edge_i = 0;
    logic        edge_mode_i = 0, fifo_mode_i = 0, auto_clr_i = 0;
    logic        wr_ctrl_i = 0, wr_start_i = 0, stat_wr_i = 0, res_rd_i = 0;
    logic [7:0]  stat_wdata_i = 0;
    logic [15:0] ccf_i = 0;
    logic [7:0]  stat_rdata_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    adc_seq_status dut (.*);

    // Vector: {req[3:0], conv,sdone,trig,busy,edge,fifo,afc,wctrl,wstart,swr,rrd,ccf, wdata, expected}
    localparam int NV = 24;
    localparam logic [31:0] VEC [NV] = '{
        {4'd8,  12'b000000001000, 8'h00, 8'h00},  // R8 start
        {4'd6,  12'b100000000000, 8'h00, 8'h01},  // R6
        {4'd6,  12'b100000000000, 8'h00, 8'h02},  // R6
        {4'd7,  12'b110000000000, 8'h00, 8'h80},  // R7 non-FIFO end zeroes
        {4'd9,  12'b000000000100, 8'h0F, 8'h80},  // R9 write keeps counter
        {4'd2,  12'b000000000100, 8'h80, 8'h00},  // R2 w1c
        {4'd5,  12'b100000000001, 8'h00, 8'h11},  // R5
        {4'd3,  12'b001110000000, 8'h00, 8'h31},  // R3 edge + busy
        {4'd4,  12'b000000010000, 8'h00, 8'h00},  // R4 abort
        {4'd3,  12'b001100000000, 8'h00, 8'h00},  // R3 level mode ignored
        {4'd3,  12'b001010000000, 8'h00, 8'h00},  // R3 not busy ignored
        {4'd7,  12'b100001000000, 8'h00, 8'h01},  // R7 FIFO
        {4'd7,  12'b110001000000, 8'h00, 8'h82},  // R7 FIFO keeps
        {4'd2,  12'b000000000010, 8'h00, 8'h82},  // R2 read without auto clear
        {4'd2,  12'b000000100010, 8'h00, 8'h02},  // R2 auto clear
        {4'd10, 12'b001110000100, 8'h20, 8'h22},  // R10 set beats w1c
        {4'd4,  12'b000000000100, 8'h20, 8'h02},  // R4 w1c
        {4'd5,  12'b100001000001, 8'h00, 8'h13},  // R5
        {4'd4,  12'b000000001000, 8'h00, 8'h00},  // R4 / R8 start
        {4'd10, 12'b010000000100, 8'h80, 8'h80},  // R10
        {4'd2,  12'b000000001000, 8'h00, 8'h00},  // R2 start clears
        {4'd1,  12'b010000000000, 8'h00, 8'h80},  // R1
        {4'd2,  12'b000000000100, 8'h80, 8'h00},  // R2
        {4'd1,  12'b010000000000, 8'h00, 8'h80}   // R1 next scan sequence
    };

    task automatic check(input int req, input logic [7:0] exp);
        checks++;
        if (stat_rdata_o !== exp) begin
            fails++;
            $display("FAIL R%0d: status actual %02h expected %02h", req, stat_rdata_o, exp);
        end
    endtask

    task automatic apply(input logic [11:0] c, input logic [7:0] wd);
        {conv_done_i, seq_done_i, trig_edge_i, seq_busy_i, edge_mode_i, fifo_mode_i,
         auto_clr_i, wr_ctrl_i, wr_start_i, stat_wr_i, res_rd_i} = c[11:1];
        ccf_i = {16{c[0]}};
        stat_wdata_i = wd;
        @(posedge clk); #2;
        {conv_done_i, seq_done_i, trig_edge_i, wr_ctrl_i, wr_start_i,
         stat_wr_i, res_rd_i} = '0;
        ccf_i = '0;
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(posedge clk); #2;
        @(posedge clk); #2;
        check(11, 8'h00);            // R11 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][27:16], VEC[i][15:8]);
            check(int'(VEC[i][31:28]), VEC[i][7:0]);
        end
        // R6 wrap in FIFO mode
        apply(12'b000000001000, 8'h00);
        for (int k = 0; k < 15; k++) apply(12'b100001000000, 8'h00);
        check(6, 8'h0F);
        apply(12'b100001000000, 8'h00);
        check(6, 8'h00);
        // R11 reset with flags and counter set
        apply(12'b010000000000, 8'h00);
        apply(12'b001110000000, 8'h00);
        apply(12'b100000000001, 8'h00);
        check(11, 8'hB1);
        rst_n = 1'b0;
        @(posedge clk); #2;
        check(11, 8'h00);
        rst_n = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule